// File: doc/BRIEF.md
# Comparison-Rate Divider with Test Steering

This block divides a reference clock down to the rate at which the phase comparator of a frequency synthesizer works. A 5-bit ratio code selects one of 29 legal division ratios, each a base of 2, 5, 6 or 7 scaled by a power of two. The divider marks the end of each comparison period with a one-cycle pulse. A new ratio is applied only when the running period ends, so a period is never cut short. A code that selects no ratio is refused: the divider keeps its last ratio and raises an error flag.

The same block holds the test logic of the synthesizer. A 3-bit test code can force the charge-pump command to sink, source or off. It can also override the lock flag that is reported, and choose what drives a general-purpose port pin. The pin can carry a static level set by a port bit, half the rate of the feedback divider, or the comparison pulse train. All of these outputs are registered, so each one follows its inputs by one cycle.

Top module: `ref_div_test`

## Requirements
- R1: When ratio code bits 4:3 are 00, the low three bits n give a comparison period of 2^(n+1) reference cycles, from 2 (code 00000) to 256 (code 00111).
- R2: When ratio code bits 4:3 are 01, 10 or 11, the base is 5, 6 or 7. Low bits n from 1 to 7 give a period of base×2^(n-1) cycles, so the largest periods are 320, 384 and 448.
- R3: Codes 01000, 10000 and 11000 are illegal. While one is applied, the divider keeps dividing by the last legal ratio, and ratio_err_o reads 1 one cycle later. ratio_err_o returns to 0 one cycle after a legal code is applied.
- R4: A ratio change takes effect only at a terminal count. The period in progress completes at its old length, and comp_pulse_o is one cycle wide and never high in two consecutive cycles.
- R5: Test codes 000 and 100 give pump command 00 (normal), and lock_flag_o follows lock_i one cycle later.
- R6: Test codes 001 and 101 give pump command 01 (sink), and test codes 010 and 110 give 10 (source). In all four, lock_flag_o is 0.
- R7: Test codes 011 and 111 give pump command 11 (off), and lock_flag_o is 1.
- R8: In test code 100 the port carries the half-rate feedback signal. In 101, 110 and 111 it carries comp_pulse_o delayed by one cycle. In those four codes port_oe_o is 1. In every other code, port_oe_o and port_o both equal port_bit_i one cycle later, where 0 means high impedance.
- R9: The half-rate feedback signal starts at 0 and toggles once for every cycle in which fb_pulse_i is high.
- R10: During reset, comp_pulse_o, pump_cmd_o, lock_flag_o, port_o, port_oe_o and ratio_err_o are all 0, so the port is high impedance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ratio_code_i | input | 5 | Division ratio selection code |
| test_code_i | input | 3 | Test mode code |
| port_bit_i | input | 1 | Static port level (1 on, 0 high impedance) |
| lock_i | input | 1 | Live lock indication from the detector |
| fb_pulse_i | input | 1 | Terminal pulse of the feedback divider |
| comp_pulse_o | output | 1 | One-cycle pulse at each comparison period end |
| pump_cmd_o | output | 2 | Pump command: 00 normal, 01 sink, 10 source, 11 off |
| lock_flag_o | output | 1 | Reported lock flag |
| port_o | output | 1 | Port pin drive value |
| port_oe_o | output | 1 | Port pin drive enable (0 = high impedance) |
| ratio_err_o | output | 1 | Illegal ratio code indicator |

## Verification
Two collisions matter most. The first is a ratio code change that lands on the edge where the counter reaches its terminal count, compared with a change that lands part way through a period. The bench provokes both by timing the code change against a known pulse. It then requires the period in progress to keep its old length and the following period to take the new one. The second collision is a feedback pulse that arrives in the same cycle that the test code moves the port from the comparison pulse to the half-rate feedback signal. The toggle must not be lost, so the port must show the toggled level two cycles later.

// File: rtl/ref_div_pkg.sv
package ref_div_pkg;
  localparam int CODE_W    = 5;
  localparam int TEST_W    = 3;
  localparam int MAX_RATIO = 448;
  localparam int RATIO_W   = $clog2(MAX_RATIO + 1);

  typedef logic [RATIO_W-1:0] ratio_t;

  typedef enum logic [1:0] {
    PUMP_NORMAL = 2'b00,
    PUMP_SINK   = 2'b01,
    PUMP_SOURCE = 2'b10,
    PUMP_OFF    = 2'b11
  } pump_cmd_e;
endpackage

// File: rtl/ref_div_decode.sv
module ref_div_decode
  import ref_div_pkg::*;
(
  input  logic [CODE_W-1:0] code_i,
  output ratio_t            ratio_o,
  output logic              valid_o
);
  logic [1:0] base_sel;
  logic [2:0] exp_sel;

  assign base_sel = code_i[4:3];
  assign exp_sel  = code_i[2:0];

  always_comb begin
    ratio_o = '0;
    valid_o = 1'b1;
    if (base_sel == 2'b00) begin
      ratio_o = ratio_t'(2) << exp_sel;
    end else if (exp_sel == 3'd0) begin
      valid_o = 1'b0;  // holes in the code space
    end else begin
      ratio_o = ratio_t'(3'd4 + {1'b0, base_sel}) << (exp_sel - 3'd1);
    end
  end
endmodule

// File: rtl/ref_div_counter.sv
module ref_div_counter
  import ref_div_pkg::*;
#(
  parameter int RESET_RATIO = 2
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  ratio_t ratio_i,
  input  logic   valid_i,
  output logic   comp_o,
  output logic   err_o
);
  ratio_t cnt_q, active_q, next_ratio;

  assign next_ratio = valid_i ? ratio_i : active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      active_q <= ratio_t'(RESET_RATIO);
      comp_o   <= 1'b0;
      err_o    <= 1'b0;
    end else begin
      err_o <= ~valid_i;
      if (cnt_q == '0) begin
        active_q <= next_ratio;
        cnt_q    <= next_ratio - ratio_t'(1);
        comp_o   <= 1'b1;
      end else begin
        cnt_q  <= cnt_q - ratio_t'(1);
        comp_o <= 1'b0;
      end
    end
  end

  // R4
  no_back_to_back_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    comp_o |=> !comp_o);
  // R4
  ratio_stable_mid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != '0) |=> $stable(active_q));
  // R3
  hold_on_illegal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(active_q));
endmodule

// File: rtl/ref_div_test_mux.sv
module ref_div_test_mux
  import ref_div_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [TEST_W-1:0] test_i,
  input  logic              lock_i,
  input  logic              port_bit_i,
  input  logic              fb_pulse_i,
  input  logic              comp_i,
  output pump_cmd_e         pump_o,
  output logic              lock_o,
  output logic              port_o,
  output logic              port_oe_o
);
  logic half_q;
  logic lock_d, port_d, oe_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) half_q <= 1'b0;
    else if (fb_pulse_i) half_q <= ~half_q;
  end

  always_comb begin
    case (test_i[1:0])
      2'b00:   lock_d = lock_i;
      2'b11:   lock_d = 1'b1;
      default: lock_d = 1'b0;
    endcase
    if (test_i == 3'b100) begin
      port_d = half_q;
      oe_d   = 1'b1;
    end else if (test_i[2] && (test_i[1:0] != 2'b00)) begin
      port_d = comp_i;
      oe_d   = 1'b1;
    end else begin
      port_d = port_bit_i;
      oe_d   = port_bit_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pump_o    <= PUMP_NORMAL;
      lock_o    <= 1'b0;
      port_o    <= 1'b0;
      port_oe_o <= 1'b0;
    end else begin
      pump_o    <= pump_cmd_e'(test_i[1:0]);
      lock_o    <= lock_d;
      port_o    <= port_d;
      port_oe_o <= oe_d;
    end
  end

  // R9
  half_toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fb_pulse_i |=> (half_q != $past(half_q)));
  // R9
  half_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fb_pulse_i |=> $stable(half_q));
  // R7
  pump_off_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (test_i[1:0] == 2'b11) |=> (lock_o && pump_o == PUMP_OFF));
  // R8
  port_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (test_i == 3'b000 && !port_bit_i) |=> !port_oe_o);
endmodule

// File: rtl/ref_div_test.sv
module ref_div_test
  import ref_div_pkg::*;
#(
  parameter int RESET_RATIO = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] ratio_code_i,
  input  logic [TEST_W-1:0] test_code_i,
  input  logic              port_bit_i,
  input  logic              lock_i,
  input  logic              fb_pulse_i,
  output logic              comp_pulse_o,
  output logic [1:0]        pump_cmd_o,
  output logic              lock_flag_o,
  output logic              port_o,
  output logic              port_oe_o,
  output logic              ratio_err_o
);
  ratio_t    dec_ratio;
  logic      dec_valid;
  pump_cmd_e pump;

  ref_div_decode u_decode (
    .code_i  (ratio_code_i),
    .ratio_o (dec_ratio),
    .valid_o (dec_valid)
  );

  ref_div_counter #(.RESET_RATIO(RESET_RATIO)) u_counter (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ratio_i (dec_ratio),
    .valid_i (dec_valid),
    .comp_o  (comp_pulse_o),
    .err_o   (ratio_err_o)
  );

  ref_div_test_mux u_test_mux (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .test_i     (test_code_i),
    .lock_i     (lock_i),
    .port_bit_i (port_bit_i),
    .fb_pulse_i (fb_pulse_i),
    .comp_i     (comp_pulse_o),
    .pump_o     (pump),
    .lock_o     (lock_flag_o),
    .port_o     (port_o),
    .port_oe_o  (port_oe_o)
  );

  assign pump_cmd_o = pump;
endmodule

// File: tb/ref_div_test_bench.sv
module ref_div_test_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] ratio_code = '0;
  logic [2:0] test_code = '0;
  logic       port_bit = 1'b0, lock_raw = 1'b0, fb_pulse = 1'b0;
  logic       comp_pulse, lock_flag, port_val, port_oe, ratio_err;
  logic [1:0] pump_cmd;

  int checks = 0, failures = 0;
  int cur_ratio = 2;
  bit exp_half = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ref_div_test u_ref_div_test (
    .clk_i(clk), .rst_ni(rst_n), .ratio_code_i(ratio_code), .test_code_i(test_code),
    .port_bit_i(port_bit), .lock_i(lock_raw), .fb_pulse_i(fb_pulse),
    .comp_pulse_o(comp_pulse), .pump_cmd_o(pump_cmd), .lock_flag_o(lock_flag),
    .port_o(port_val), .port_oe_o(port_oe), .ratio_err_o(ratio_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_ratio(input int code);
    int hi = code >> 3;
    int n  = code & 7;
    if (hi == 0) return 2 ** (n + 1);
    if (n == 0) return -1;
    return (4 + hi) * (2 ** (n - 1));
  endfunction

  task automatic measure(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!comp_pulse && n < 1000);
  endtask

  task automatic check_ratio(input int code);
    int n, e;
    string req;
    e = exp_ratio(code);
    req = (e < 0) ? "R3" : ((code < 8) ? "R1" : "R2");
    ratio_code = code[4:0];
    measure(n);
    measure(n);
    measure(n);
    if (e < 0) e = cur_ratio;
    else cur_ratio = e;
    chk(n == e, req, n, e);
    chk(ratio_err == (exp_ratio(code) < 0), "R3", ratio_err, exp_ratio(code) < 0);
  endtask

  task automatic pulse_fb();
    fb_pulse = 1'b1;
    @(negedge clk);
    fb_pulse = 1'b0;
    exp_half = ~exp_half;
    @(negedge clk);
  endtask

  initial begin
    int n;
    int unsigned seed;
    bit prev;
    int dir [11] = '{0, 7, 9, 31, 23, 15, 3, 8, 16, 24, 25};
    seed = $urandom(32'd20240611);

    repeat (3) @(negedge clk);
    // R10 reset state
    chk(!comp_pulse && !ratio_err, "R10", comp_pulse, 0);
    chk(pump_cmd == 2'b00 && !lock_flag, "R10", pump_cmd, 0);
    chk(!port_oe && !port_val, "R10", port_oe, 0);
    rst_n = 1'b1;

    foreach (dir[i]) check_ratio(dir[i]);
    for (int k = 0; k < 25; k++) check_ratio(int'($urandom_range(0, 31)));

    // R4: change mid-period, then on the terminal-count edge
    check_ratio(2);
    n = 0;
    do begin
      @(negedge clk); n++;
      if (n == 3) ratio_code = 5'd4;
    end while (!comp_pulse && n < 1000);
    chk(n == 8, "R4", n, 8);
    measure(n);
    chk(n == 32, "R4", n, 32);
    n = 0;
    do begin
      @(negedge clk); n++;
      if (n == 31) ratio_code = 5'd1;
    end while (!comp_pulse && n < 1000);
    chk(n == 32, "R4", n, 32);
    measure(n);
    chk(n == 4, "R4", n, 4);
    ratio_code = 5'd0;
    measure(n);
    measure(n);

    // R5 R6 R7 test codes
    for (int t = 0; t < 8; t++) begin
      string req;
      int el;
      test_code = t[2:0];
      lock_raw = 1'($urandom_range(0, 1));
      port_bit = 1'b0;
      @(negedge clk);
      req = (t[1:0] == 0) ? "R5" : ((t[1:0] == 3) ? "R7" : "R6");
      el = (t[1:0] == 0) ? int'(lock_raw) : ((t[1:0] == 3) ? 1 : 0);
      chk(pump_cmd == t[1:0], req, pump_cmd, t[1:0]);
      chk(lock_flag == el, req, lock_flag, el);
    end
    test_code = 3'b000;
    lock_raw = 1'b1;
    @(negedge clk);
    chk(lock_flag == 1'b1, "R5", lock_flag, 1);
    lock_raw = 1'b0;
    @(negedge clk);
    chk(lock_flag == 1'b0, "R5", lock_flag, 0);

    // R8 static port bit
    port_bit = 1'b1;
    @(negedge clk);
    chk(port_oe && port_val, "R8", port_oe, 1);
    port_bit = 1'b0;
    @(negedge clk);
    chk(!port_oe, "R8", port_oe, 0);

    // R8 comparison pulse on port
    for (int m = 5; m < 8; m++) begin
      test_code = m[2:0];
      @(negedge clk);
      prev = comp_pulse;
      for (int c = 0; c < 6; c++) begin
        @(negedge clk);
        chk(port_oe && port_val == prev, "R8", port_val, prev);
        prev = comp_pulse;
      end
    end

    // R9 half-rate feedback on port
    test_code = 3'b100;
    @(negedge clk);
    chk(port_oe && port_val == exp_half, "R9", port_val, exp_half);
    for (int p = 0; p < 5; p++) begin
      pulse_fb();
      chk(port_val == exp_half, "R9", port_val, exp_half);
      repeat ($urandom_range(0, 3)) @(negedge clk);
    end

    // R9 feedback pulse in the cycle the port source switches
    test_code = 3'b101;
    @(negedge clk);
    test_code = 3'b100;
    pulse_fb();
    chk(port_val == exp_half && port_oe, "R9", port_val, exp_half);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL R4 watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule